// File: doc/BRIEF.md
# Interlaced 4:2:2 Video Word Stream Generator

This block drives the 8-bit digital input of an external composite video encoder. On every clock it emits one word of an interlaced 4:2:2 component stream. Each line holds an end-of-active-video reference code, a horizontal blanking fill, a start-of-active-video reference code and the active component words. Line sync, field sync and vertical blanking are not on separate wires. They are carried inside the stream as four-word reference codes whose status word holds protected field (F), vertical-blank (V) and horizontal (H) flags.

With the default parameters, a line is 858 pixel times (1716 words) and a frame is 525 lines split into two fields. Active lines carry 720 pixels, and 487 lines of the frame are visible. A registered upstream pixel source answers a one-cycle-ahead request with a 16-bit pair of chroma and luma. The block sends the chroma byte first and the luma byte second. On lines inside vertical blanking the active region carries blanking fill and no request is raised.

The line sequencer is a four-state machine. Its states are SEG_EAV (4 words), SEG_HFILL (fill words), SEG_SAV (4 words) and SEG_ACTIVE (active words). Its transitions are: EAV to HFILL after the fourth reference word, HFILL to SAV after the last fill word, SAV to ACTIVE after the fourth reference word, and ACTIVE to EAV after the last active word. The ACTIVE-to-EAV transition also advances the line number, and line LINES wraps to line 1.

Top module: `vsg_gen`

## Requirements
- R1: While rst_n is low: vid_q = 0x10, pix_req = 0, line_no = 1 and field = 1.
- R2: The first word after reset release is the first word of line 1. Each line is 2*PX_TOTAL words in this order: 4 EAV words, 2*(PX_TOTAL-PX_ACTIVE)-8 fill words, 4 SAV words, then 2*PX_ACTIVE active words.
- R3: Each reference code is the words 0xFF, 0x00, 0x00 followed by a status word. The status word bits, from bit 7 down to bit 0, are 1, F, V, H, V^H, F^H, F^V, F^V^H. H is 1 in EAV and 0 in SAV.
- R4: Horizontal blanking alternates 0x80 and 0x10, starting with 0x80.
- R5: F is 0 on lines 4 to 265 inclusive and 1 on all other lines. The field output shows F of the line of the word currently on vid_q.
- R6: V is 1 on lines 1–19 and 264–282. On those lines the active region carries the R4 fill pattern (starting 0x80) and pix_req stays 0.
- R7: pix_req is high in a cycle exactly when the word emitted two clock edges later is the chroma word of a pixel. pix_in sampled at the next edge supplies that pixel. Active word 2k is pix_in[15:8] of pixel k and word 2k+1 is pix_in[7:0], so the source's Cb, Y, Cr, Y order is kept. pix_req is never high in two consecutive cycles.
- R8: line_no gives the line (1..LINES) of the word on vid_q. It advances by one at each line boundary and wraps from LINES to 1.
- R9: The luma word comes from the pair sampled with its chroma word, whatever pix_in holds in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock (27 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_in | input | 16 | Pixel pair {chroma, luma} from a registered source |
| vid_q | output | 8 | Registered stream word |
| pix_req | output | 1 | Request for the next pixel pair |
| line_no | output | 10 | Line number of the word on vid_q |
| field | output | 1 | F flag of the word on vid_q |

## Verification
The bench models a registered pixel source. It answers each request with a random pair in the range 0x01–0xFE and drives random filler on pix_in in every other cycle. Comparing each luma word against the pair sampled at the request shows whether the chroma/luma order is correct, whether the luma byte is held, and whether the sample is taken one cycle too early or too late. The bench runs two full frames with shortened lines, which covers both field transitions, both vertical-blanking bands and the 525-to-1 wrap. A reset applied in the middle of a frame checks that the sequence restarts at line 1.

// File: rtl/vsg_pkg.sv
`timescale 1ns/1ps
package vsg_pkg;

    typedef enum logic [1:0] {
        SEG_EAV    = 2'd0,
        SEG_HFILL  = 2'd1,
        SEG_SAV    = 2'd2,
        SEG_ACTIVE = 2'd3
    } seg_t;

    localparam logic [7:0] WORD_LEAD  = 8'hFF;
    localparam logic [7:0] WORD_ZERO  = 8'h00;
    localparam logic [7:0] FILL_CHR   = 8'h80;
    localparam logic [7:0] FILL_LUM   = 8'h10;
    localparam logic [7:0] IDLE_WORD  = 8'h10;

    // status word: 1, F, V, H, then four protection bits
    function automatic logic [7:0] ref_status(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/vsg_line_seq.sv
`timescale 1ns/1ps
module vsg_line_seq
    import vsg_pkg::*;
#(
    parameter int FILL_WORDS = 268,
    parameter int ACT_WORDS  = 1440,
    parameter int LINES      = 525,
    parameter int CW         = 11,
    parameter int LW         = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    output seg_t          seg,
    output logic [1:0]    pos_lsb,
    output logic [LW-1:0] line,
    output seg_t          nseg,
    output logic          npos_odd,
    output logic [LW-1:0] nline
);

    localparam logic [CW-1:0] REF_END  = CW'(3);
    localparam logic [CW-1:0] FILL_END = CW'(FILL_WORDS - 1);
    localparam logic [CW-1:0] ACT_END  = CW'(ACT_WORDS - 1);
    localparam logic [LW-1:0] LINE_TOP = LW'(LINES);
    localparam logic [LW-1:0] LINE_ONE = LW'(1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] ncnt;
    logic          seg_done;

    // next-state process
    always_comb begin
        nseg     = seg;
        nline    = line;
        seg_done = 1'b0;
        unique case (seg)
            SEG_EAV: begin
                seg_done = (cnt == REF_END);
                if (seg_done) nseg = SEG_HFILL;
            end
            SEG_HFILL: begin
                seg_done = (cnt == FILL_END);
                if (seg_done) nseg = SEG_SAV;
            end
            SEG_SAV: begin
                seg_done = (cnt == REF_END);
                if (seg_done) nseg = SEG_ACTIVE;
            end
            SEG_ACTIVE: begin
                seg_done = (cnt == ACT_END);
                if (seg_done) begin
                    nseg  = SEG_EAV;
                    nline = (line == LINE_TOP) ? LINE_ONE : line + LINE_ONE;
                end
            end
        endcase
        ncnt = seg_done ? '0 : cnt + CW'(1);
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg  <= SEG_EAV;
            cnt  <= '0;
            line <= LINE_ONE;
        end else begin
            seg  <= nseg;
            cnt  <= ncnt;
            line <= nline;
        end
    end

    assign pos_lsb  = cnt[1:0];
    assign npos_odd = ncnt[0];

endmodule

// File: rtl/vsg_flag_dec.sv
`timescale 1ns/1ps
module vsg_flag_dec #(
    parameter int LW        = 10,
    parameter int F0_FIRST  = 4,
    parameter int F0_LAST   = 265,
    parameter int VB1_LAST  = 19,
    parameter int VB2_FIRST = 264,
    parameter int VB2_LAST  = 282
) (
    input  logic [LW-1:0] line,
    output logic          f,
    output logic          v
);

    localparam logic [LW-1:0] F0A = LW'(F0_FIRST);
    localparam logic [LW-1:0] F0B = LW'(F0_LAST);
    localparam logic [LW-1:0] V1B = LW'(VB1_LAST);
    localparam logic [LW-1:0] V2A = LW'(VB2_FIRST);
    localparam logic [LW-1:0] V2B = LW'(VB2_LAST);

    always_comb begin
        f = !((line >= F0A) && (line <= F0B));
        v = (line <= V1B) || ((line >= V2A) && (line <= V2B));
    end

endmodule

// File: rtl/vsg_word_mux.sv
`timescale 1ns/1ps
module vsg_word_mux
    import vsg_pkg::*;
#(
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seg_t          seg,
    input  logic [1:0]    pos_lsb,
    input  logic [LW-1:0] line,
    input  logic          f,
    input  logic          v,
    input  logic [15:0]   pix_in,
    output logic [7:0]    vid_q,
    output logic [LW-1:0] line_q,
    output logic          field_q
);

    logic [7:0] word_d;
    logic [7:0] luma_hold;
    logic       take_pair;

    // output word process
    always_comb begin
        word_d    = IDLE_WORD;
        take_pair = 1'b0;
        unique case (seg)
            SEG_EAV, SEG_SAV: begin
                case (pos_lsb)
                    2'd0:    word_d = WORD_LEAD;
                    2'd3:    word_d = ref_status(f, v, seg == SEG_EAV);
                    default: word_d = WORD_ZERO;
                endcase
            end
            SEG_HFILL: word_d = pos_lsb[0] ? FILL_LUM : FILL_CHR;
            SEG_ACTIVE: begin
                if (v) begin
                    word_d = pos_lsb[0] ? FILL_LUM : FILL_CHR;
                end else if (pos_lsb[0]) begin
                    word_d = luma_hold;
                end else begin
                    word_d    = pix_in[15:8];
                    take_pair = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vid_q     <= IDLE_WORD;
            line_q    <= LW'(1);
            field_q   <= 1'b1;
            luma_hold <= '0;
        end else begin
            vid_q   <= word_d;
            line_q  <= line;
            field_q <= f;
            if (take_pair) luma_hold <= pix_in[7:0];
        end
    end

endmodule

// File: rtl/vsg_gen.sv
`timescale 1ns/1ps
module vsg_gen
    import vsg_pkg::*;
#(
    parameter int PX_TOTAL  = 858,
    parameter int PX_ACTIVE = 720,
    parameter int LINES     = 525,
    parameter int F0_FIRST  = 4,
    parameter int F0_LAST   = 265,
    parameter int VB1_LAST  = 19,
    parameter int VB2_FIRST = 264,
    parameter int VB2_LAST  = 282
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] pix_in,
    output logic [7:0]  vid_q,
    output logic        pix_req,
    output logic [9:0]  line_no,
    output logic        field
);

    localparam int WL = 2 * PX_TOTAL;
    localparam int WA = 2 * PX_ACTIVE;
    localparam int WF = WL - WA - 8;
    localparam int CW = $clog2(WL);
    localparam int LW = 10;

    seg_t          seg, nseg;
    logic [1:0]    pos_lsb;
    logic          npos_odd;
    logic [LW-1:0] line, nline;
    logic          f_cur, v_cur, f_nxt, v_nxt;

    vsg_line_seq #(
        .FILL_WORDS(WF), .ACT_WORDS(WA), .LINES(LINES), .CW(CW), .LW(LW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .seg(seg), .pos_lsb(pos_lsb), .line(line),
        .nseg(nseg), .npos_odd(npos_odd), .nline(nline)
    );

    vsg_flag_dec #(
        .LW(LW), .F0_FIRST(F0_FIRST), .F0_LAST(F0_LAST),
        .VB1_LAST(VB1_LAST), .VB2_FIRST(VB2_FIRST), .VB2_LAST(VB2_LAST)
    ) u_flag_cur (.line(line), .f(f_cur), .v(v_cur));

    vsg_flag_dec #(
        .LW(LW), .F0_FIRST(F0_FIRST), .F0_LAST(F0_LAST),
        .VB1_LAST(VB1_LAST), .VB2_FIRST(VB2_FIRST), .VB2_LAST(VB2_LAST)
    ) u_flag_nxt (.line(nline), .f(f_nxt), .v(v_nxt));

    vsg_word_mux #(.LW(LW)) u_mux (
        .clk(clk), .rst_n(rst_n),
        .seg(seg), .pos_lsb(pos_lsb), .line(line), .f(f_cur), .v(v_cur),
        .pix_in(pix_in), .vid_q(vid_q), .line_q(line_no), .field_q(field)
    );

    // next position is a chroma word of a visible line: ask for its pair now
    assign pix_req = (nseg == SEG_ACTIVE) && !v_nxt && !npos_odd && rst_n;

    logic f_nxt_unused;
    assign f_nxt_unused = f_nxt;

endmodule

// File: rtl/vsg_chk.sv
`timescale 1ns/1ps
module vsg_chk #(
    parameter int LINES = 525
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] vid_q,
    input logic       pix_req,
    input logic [9:0] line_no,
    input logic       field
);

    // R3: a lead word is always followed by a zero word
    a_r3_lead_then_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_q == 8'hFF) |=> (vid_q == 8'h00));

    // R3: the word after FF 00 00 is a status word with consistent protection
    a_r3_status_prot: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(vid_q, 3) == 8'hFF && $past(vid_q, 2) == 8'h00 && $past(vid_q) == 8'h00)
        |-> (vid_q[7] && vid_q[3] == (vid_q[5] ^ vid_q[4]) && vid_q[2] == (vid_q[6] ^ vid_q[4])
             && vid_q[1] == (vid_q[6] ^ vid_q[5]) && vid_q[0] == (vid_q[6] ^ vid_q[5] ^ vid_q[4])));

    // R7: one request per pixel, never back to back
    a_r7_req_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |=> !pix_req);

    // R8: line number stays inside the frame
    a_r8_line_range: assert property (@(posedge clk) disable iff (!rst_n)
        (line_no >= 10'd1) && (line_no <= 10'(LINES)));

    // R8: line number steps by one or wraps to 1
    a_r8_line_step: assert property (@(posedge clk) disable iff (!rst_n)
        (line_no != $past(line_no)) |->
        ((line_no == $past(line_no) + 10'd1) || (line_no == 10'd1 && $past(line_no) == 10'(LINES))));

    // R5: field changes only at a line boundary
    a_r5_field_on_line: assert property (@(posedge clk) disable iff (!rst_n)
        (field != $past(field)) |-> (line_no != $past(line_no)));

endmodule

bind vsg_gen vsg_chk #(.LINES(LINES)) u_vsg_chk (
    .clk(clk), .rst_n(rst_n), .vid_q(vid_q), .pix_req(pix_req),
    .line_no(line_no), .field(field)
);

// File: tb/vsg_gen_tb_top.sv
`timescale 1ns/1ps
module vsg_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PXT   = 24;
    localparam int PXA   = 16;
    localparam int NLINE = 525;
    localparam int WL    = 2 * PXT;
    localparam int WF    = WL - 2 * PXA - 8;
    localparam int ACT0  = WF + 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pix_in = 16'h0;
    logic [7:0]  vid_q;
    logic        pix_req;
    logic [9:0]  line_no;
    logic        field;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] pair_q[$];
    logic [7:0]  exp_luma;
    logic        prev_req;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vsg_gen #(.PX_TOTAL(PXT), .PX_ACTIVE(PXA), .LINES(NLINE)) dut_i (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .vid_q(vid_q),
        .pix_req(pix_req), .line_no(line_no), .field(field)
    );

    function automatic int line_of(input int w);
        return (w / WL) % NLINE + 1;
    endfunction
    function automatic logic f_of(input int l);
        return !(l >= 4 && l <= 265);
    endfunction
    function automatic logic v_of(input int l);
        return (l <= 19) || (l >= 264 && l <= 282);
    endfunction
    function automatic logic [7:0] status(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction
    function automatic logic is_chroma(input int w);
        int c = w % WL;
        return (c >= ACT0) && (((c - ACT0) % 2) == 0) && !v_of(line_of(w));
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_reset();
        check("R1 vid_q", vid_q, 8'h10);
        check("R1 pix_req", pix_req, 0);
        check("R1 line_no", line_no, 1);
        check("R1 field", field, 1);
    endtask

    // one cycle of checks after edge n, then drive the source
    task automatic step(input int n);
        int w = n - 1;
        int c = w % WL;
        int l = line_of(w);
        logic [15:0] pr;
        string tag;
        int exp;
        tag = "R4 hfill";
        if (c < 4 || (c >= WF + 4 && c < ACT0)) begin
            tag = "R2 R3 refcode";
            case (c % 4)
                0: exp = 8'hFF;
                3: exp = status(f_of(l), v_of(l), c < 4);
                default: exp = 8'h00;
            endcase
        end else if (c < WF + 4) begin
            exp = ((c - 4) % 2 == 0) ? 8'h80 : 8'h10;
        end else if (v_of(l)) begin
            tag = "R6 vblank fill";
            exp = ((c - ACT0) % 2 == 0) ? 8'h80 : 8'h10;
        end else if ((c - ACT0) % 2 == 0) begin
            tag = "R7 chroma";
            if (pair_q.size() == 0) begin
                exp = -1;
            end else begin
                pr = pair_q.pop_front();
                exp = pr[15:8];
                exp_luma = pr[7:0];
            end
        end else begin
            tag = "R9 luma hold";
            exp = exp_luma;
        end
        check(tag, vid_q, exp);
        check("R8 line_no", line_no, l);
        check("R5 field", field, f_of(l));
        check("R7 pix_req", pix_req, is_chroma(n + 1));
        if (pix_req) begin
            pr = {8'($urandom_range(254, 1)), 8'($urandom_range(254, 1))};
            pix_in = pr;
            pair_q.push_back(pr);
            prev_req = 1'b1;
        end else begin
            if (!prev_req) pix_in = 16'($urandom);
            prev_req = 1'b0;
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0656));
        prev_req = 1'b0;
        exp_luma = 8'h00;
        repeat (3) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        // two full frames: both fields, both blanking bands, wrap to line 1
        for (int n = 1; n <= 2 * NLINE * WL + 200; n++) begin
            @(negedge clk);
            step(n);
        end
        // directed: reset in the middle of a frame restarts at line 1
        rst_n = 1'b0;
        pair_q.delete();
        prev_req = 1'b0;
        repeat (2) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        for (int n = 1; n <= 30 * WL; n++) begin
            @(negedge clk);
            step(n);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule